// File: doc/BRIEF.md
# Banked 24-bit Effective Address Generator

This block turns the register state of an 8/16-bit CPU with bank registers into a 24-bit bus address. The sequencer picks an addressing mode for each bus cycle. The block then joins a bank byte to a 16-bit offset, or it adds a displacement or an index to get the address.

It covers three kinds of address:
- **Program addresses** take the program bank as their high byte. Their offset arithmetic stays inside that bank.
- **Data addresses** take the data bank register above an absolute operand. Indexing can carry into the bank byte. Long operands bypass the bank register.
- **Bank-zero addresses** cover direct page and stack references. These always stay in bank 0. In emulation mode the stack pointer is confined to page one.

The request is sampled on a qualifying clock edge. The address appears one cycle later on a registered output, and stays there until the next request.

Top module: `addrgen_top`

## Requirements
- R1: While reset is active, and until the first request after reset, `addr` is 0x000000 and `addr_valid` is 0.
- R2: Mode code 0 (program fetch) yields `{pbr, pc}`.
- R3: Mode code 1 (next fetch) yields `{pbr, pc+1}`. The 16-bit offset wraps from 0xFFFF to 0x0000 and the bank byte stays `pbr`.
- R4: Mode code 2 (program-relative long) yields `{pbr, pc + operand[15:0]}`. The displacement is two's complement and the sum wraps within the bank.
- R5: Mode code 3 (interrupt fetch) yields `{0x00, pc}` whatever the value of `pbr`.
- R6: Mode code 4 (absolute) yields `{dbr, operand[15:0]}`. `operand[23:16]` has no effect.
- R7: Mode code 5 (absolute indexed) yields `({dbr, operand[15:0]} + index) mod 2^24`. A carry out of bit 15 increments the bank byte.
- R8: Mode code 6 (long) yields `operand[23:0]`. `dbr` has no effect.
- R9: Mode code 7 (direct page) yields `{0x00, (dpage + operand[7:0]) mod 2^16}`. `operand[23:8]` has no effect.
- R10: Mode code 8 (stack) yields `{0x00, sp}` when `emu` is 0, and `{0x00, 0x01, sp[7:0]}` when `emu` is 1.
- R11: Mode code 9 (stack relative) yields `{0x00, (sp + operand[7:0]) mod 2^16}`.
- R12: Mode codes 10 to 15 yield address 0x000000 with `addr_valid` set.
- R13: A request sampled on a rising edge appears on `addr` after that edge, with `addr_valid` at 1. On an edge with `req_valid` at 0, `addr` keeps its value and `addr_valid` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Sample the request on this edge |
| mode | input | 4 | Addressing mode code |
| emu | input | 1 | Emulation mode flag |
| pc | input | 16 | Program counter |
| operand | input | 24 | Operand bytes: displacement, absolute, long or 8-bit offset |
| index | input | 16 | Index register value |
| dpage | input | 16 | Direct page base |
| sp | input | 16 | Stack pointer |
| pbr | input | 8 | Program bank |
| dbr | input | 8 | Data bank |
| addr_valid | output | 1 | Registered address is fresh |
| addr | output | 24 | Registered effective address |

## Verification
The hardest cases are the ones where arithmetic crosses a boundary and the mode says whether the carry may leave the 16-bit field.

The stimulus places the operands right at those edges:
- a PC of 0xFFFF for the next fetch;
- a backward displacement for the relative mode;
- a direct page base of 0xFFF0 with a large offset;
- a stack pointer of 0xFFFF with an offset.

For the absolute indexed mode, the offset and index are chosen so the sum crosses bit 15, including a case where the carry also leaves the bank byte.

Unused operand bytes and bank registers carry non-zero patterns, so an address that draws on them shows it.

// File: rtl/addrgen_pkg.sv
package addrgen_pkg;
  localparam int BANK_W = 8;
  localparam int OFS_W  = 16;
  localparam int ADDR_W = BANK_W + OFS_W;
  localparam int MODE_W = 4;
  localparam int NEAR_W = 8;

  localparam logic [BANK_W-1:0] EMU_STACK_PAGE = 8'h01;

  typedef enum logic [MODE_W-1:0] {
    AM_FETCH     = 4'd0,
    AM_FETCH_NXT = 4'd1,
    AM_PC_REL    = 4'd2,
    AM_INT_FETCH = 4'd3,
    AM_ABS       = 4'd4,
    AM_ABS_IDX   = 4'd5,
    AM_LONG      = 4'd6,
    AM_DIRECT    = 4'd7,
    AM_STACK     = 4'd8,
    AM_STACK_REL = 4'd9
  } amode_e;

  typedef enum logic [1:0] {
    GRP_PROG = 2'd0,
    GRP_DATA = 2'd1,
    GRP_ZERO = 2'd2,
    GRP_NONE = 2'd3
  } agroup_e;
endpackage

// File: rtl/addrgen_prog_path.sv
module addrgen_prog_path #(
  parameter int BW = 8,
  parameter int OW = 16
) (
  input  logic [BW-1:0]    pbr,
  input  logic [OW-1:0]    pc,
  input  logic [OW-1:0]    disp,
  input  logic [1:0]       sel,
  output logic [BW+OW-1:0] addr
);
  logic [OW-1:0] ofs;
  logic [BW-1:0] bank;

  always_comb begin
    bank = pbr;
    ofs  = pc;
    case (sel)
      2'd1:    ofs = pc + OW'(1);
      2'd2:    ofs = pc + disp;
      2'd3:    bank = '0;
      default: ofs = pc;
    endcase
  end

  assign addr = {bank, ofs};
endmodule

// File: rtl/addrgen_data_path.sv
module addrgen_data_path #(
  parameter int BW = 8,
  parameter int OW = 16
) (
  input  logic [BW-1:0]    dbr,
  input  logic [BW+OW-1:0] operand,
  input  logic [OW-1:0]    index,
  input  logic [1:0]       sel,
  output logic [BW+OW-1:0] addr
);
  localparam int AW = BW + OW;

  logic [AW-1:0] banked;
  logic [AW-1:0] indexed;

  assign banked  = {dbr, operand[OW-1:0]};
  assign indexed = banked + {{BW{1'b0}}, index};

  always_comb begin
    case (sel)
      2'd0:    addr = banked;
      2'd1:    addr = indexed;
      2'd2:    addr = operand;
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/addrgen_zero_path.sv
module addrgen_zero_path #(
  parameter int                BW      = 8,
  parameter int                OW      = 16,
  parameter int                NW      = 8,
  parameter logic [BW-1:0]     EPAGE   = 8'h01
) (
  input  logic [OW-1:0]    dpage,
  input  logic [OW-1:0]    sp,
  input  logic [NW-1:0]    near_ofs,
  input  logic             emu,
  input  logic [1:0]       sel,
  output logic [BW+OW-1:0] addr
);
  localparam int LOW_W = OW - BW;

  logic [OW-1:0] near_ext;
  logic [OW-1:0] stack_ofs;
  logic [OW-1:0] ofs;

  assign near_ext = {{(OW-NW){1'b0}}, near_ofs};

  generate
    if (OW > BW) begin : g_emu_page
      assign stack_ofs = emu ? {EPAGE, sp[LOW_W-1:0]} : sp;
    end else begin : g_flat
      assign stack_ofs = sp;
    end
  endgenerate

  always_comb begin
    case (sel)
      2'd0:    ofs = dpage + near_ext;
      2'd1:    ofs = stack_ofs;
      2'd2:    ofs = sp + near_ext;
      default: ofs = '0;
    endcase
  end

  assign addr = {{BW{1'b0}}, ofs};
endmodule

// File: rtl/addrgen_top.sv
module addrgen_top
  import addrgen_pkg::*;
#(
  parameter int BW = BANK_W,
  parameter int OW = OFS_W,
  parameter int NW = NEAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       mode,
  input  logic             emu,
  input  logic [15:0]      pc,
  input  logic [23:0]      operand,
  input  logic [15:0]      index,
  input  logic [15:0]      dpage,
  input  logic [15:0]      sp,
  input  logic [7:0]       pbr,
  input  logic [7:0]       dbr,
  output logic             addr_valid,
  output logic [23:0]      addr
);
  localparam int AW = BW + OW;

  logic [1:0]    rst_pipe;
  logic          rst_sync;
  agroup_e       grp;
  logic [1:0]    sub_sel;
  logic [AW-1:0] prog_addr;
  logic [AW-1:0] data_addr;
  logic [AW-1:0] zero_addr;
  logic [AW-1:0] addr_d;
  logic [AW-1:0] addr_q;
  logic          valid_d;
  logic          valid_q;
  logic          load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  always_comb begin
    grp     = GRP_NONE;
    sub_sel = 2'd0;
    case (amode_e'(mode))
      AM_FETCH:     begin grp = GRP_PROG; sub_sel = 2'd0; end
      AM_FETCH_NXT: begin grp = GRP_PROG; sub_sel = 2'd1; end
      AM_PC_REL:    begin grp = GRP_PROG; sub_sel = 2'd2; end
      AM_INT_FETCH: begin grp = GRP_PROG; sub_sel = 2'd3; end
      AM_ABS:       begin grp = GRP_DATA; sub_sel = 2'd0; end
      AM_ABS_IDX:   begin grp = GRP_DATA; sub_sel = 2'd1; end
      AM_LONG:      begin grp = GRP_DATA; sub_sel = 2'd2; end
      AM_DIRECT:    begin grp = GRP_ZERO; sub_sel = 2'd0; end
      AM_STACK:     begin grp = GRP_ZERO; sub_sel = 2'd1; end
      AM_STACK_REL: begin grp = GRP_ZERO; sub_sel = 2'd2; end
      default:      begin grp = GRP_NONE; sub_sel = 2'd0; end
    endcase
  end

  addrgen_prog_path #(.BW(BW), .OW(OW)) u_prog (
    .pbr  (pbr),
    .pc   (pc),
    .disp (operand[OW-1:0]),
    .sel  (sub_sel),
    .addr (prog_addr)
  );

  addrgen_data_path #(.BW(BW), .OW(OW)) u_data (
    .dbr     (dbr),
    .operand (operand),
    .index   (index),
    .sel     (sub_sel),
    .addr    (data_addr)
  );

  addrgen_zero_path #(.BW(BW), .OW(OW), .NW(NW), .EPAGE(EMU_STACK_PAGE)) u_zero (
    .dpage    (dpage),
    .sp       (sp),
    .near_ofs (operand[NW-1:0]),
    .emu      (emu),
    .sel      (sub_sel),
    .addr     (zero_addr)
  );

  assign load_en = req_valid;

  always_comb begin
    valid_d = load_en;
    addr_d  = addr_q;
    if (load_en) begin
      case (grp)
        GRP_PROG: addr_d = prog_addr;
        GRP_DATA: addr_d = data_addr;
        GRP_ZERO: addr_d = zero_addr;
        default:  addr_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
    end
  end

  assign addr       = addr_q;
  assign addr_valid = valid_q;
endmodule

// File: rtl/addrgen_chk.sv
module addrgen_chk (
  input logic        clk,
  input logic        rst_sync,
  input logic        req_valid,
  input logic [3:0]  mode,
  input logic        emu,
  input logic [15:0] pc,
  input logic [23:0] operand,
  input logic [7:0]  pbr,
  input logic [7:0]  dbr,
  input logic        addr_valid,
  input logic [23:0] addr
);
  a_r2_fetch_join: assert property (@(posedge clk) disable iff (!rst_sync)
    (req_valid && mode == 4'd0) |=> (addr == {$past(pbr), $past(pc)}));

  a_r3_next_keeps_bank: assert property (@(posedge clk) disable iff (!rst_sync)
    (req_valid && mode == 4'd1) |=> (addr[23:16] == $past(pbr)));

  a_r5_int_bank_zero: assert property (@(posedge clk) disable iff (!rst_sync)
    (req_valid && mode == 4'd3) |=> (addr == {8'h00, $past(pc)}));

  a_r6_abs_dbr: assert property (@(posedge clk) disable iff (!rst_sync)
    (req_valid && mode == 4'd4) |=> (addr == {$past(dbr), $past(operand[15:0])}));

  a_r8_long_bypass: assert property (@(posedge clk) disable iff (!rst_sync)
    (req_valid && mode == 4'd6) |=> (addr == $past(operand)));

  a_r9_direct_bank0: assert property (@(posedge clk) disable iff (!rst_sync)
    (req_valid && mode == 4'd7) |=> (addr[23:16] == 8'h00));

  a_r10_emu_stack_page: assert property (@(posedge clk) disable iff (!rst_sync)
    (req_valid && mode == 4'd8 && emu) |=> (addr[23:8] == 16'h0001));

  a_r13_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync)
    req_valid |=> addr_valid);

  a_r13_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync)
    !req_valid |=> (!addr_valid && $stable(addr)));
endmodule

bind addrgen_top addrgen_chk u_chk (
  .clk        (clk),
  .rst_sync   (rst_sync),
  .req_valid  (req_valid),
  .mode       (mode),
  .emu        (emu),
  .pc         (pc),
  .operand    (operand),
  .pbr        (pbr),
  .dbr        (dbr),
  .addr_valid (addr_valid),
  .addr       (addr)
);

// File: tb/addrgen_top_bench.sv
module addrgen_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  mode = '0;
  logic        emu = 1'b0;
  logic [15:0] pc = '0;
  logic [23:0] operand = '0;
  logic [15:0] index = '0;
  logic [15:0] dpage = '0;
  logic [15:0] sp = '0;
  logic [7:0]  pbr = '0;
  logic [7:0]  dbr = '0;
  logic        addr_valid;
  logic [23:0] addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addrgen_top u_addrgen_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .emu(emu),
    .pc(pc), .operand(operand), .index(index), .dpage(dpage), .sp(sp),
    .pbr(pbr), .dbr(dbr), .addr_valid(addr_valid), .addr(addr)
  );

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%06h expected=%06h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] m);
    @(negedge clk);
    mode = m;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R13 valid", {23'd0, addr_valid}, 24'd1);
  endtask

  task automatic t_reset;
    check("R1 reset addr", addr, 24'h000000);
    check("R1 reset valid", {23'd0, addr_valid}, 24'd0);
  endtask

  task automatic t_fetch;
    pbr = 8'h12; pc = 16'h3456; dbr = 8'h99; operand = 24'hABCDEF;
    issue(4'd0); check("R2 fetch", addr, 24'h123456);
    pbr = 8'h7E; pc = 16'hFFFF;
    issue(4'd1); check("R3 next wrap", addr, 24'h7E0000);
    pc = 16'h1234;
    issue(4'd1); check("R3 next", addr, 24'h7E1235);
  endtask

  task automatic t_pcrel;
    pbr = 8'h05; pc = 16'hFFF0; operand = 24'hEE0020;
    issue(4'd2); check("R4 fwd wrap", addr, 24'h050010);
    pc = 16'h1000; operand = 24'h00FFFE;
    issue(4'd2); check("R4 backward", addr, 24'h050FFE);
  endtask

  task automatic t_int;
    pbr = 8'hAB; pc = 16'hFFFE;
    issue(4'd3); check("R5 int bank0", addr, 24'h00FFFE);
  endtask

  task automatic t_data;
    dbr = 8'h7F; operand = 24'h99ABCD;
    issue(4'd4); check("R6 abs", addr, 24'h7FABCD);
    dbr = 8'h01; operand = 24'h33FFF0; index = 16'h0020;
    issue(4'd5); check("R7 carry bank", addr, 24'h020010);
    dbr = 8'h10; operand = 24'h001000; index = 16'h0234;
    issue(4'd5); check("R7 plain", addr, 24'h101234);
    dbr = 8'hFF; operand = 24'h00FFFF; index = 16'h0001;
    issue(4'd5); check("R7 top wrap", addr, 24'h000000);
    dbr = 8'h55; operand = 24'hC0FFEE;
    issue(4'd6); check("R8 long", addr, 24'hC0FFEE);
  endtask

  task automatic t_direct;
    dpage = 16'hFFF0; operand = 24'hABCD20;
    issue(4'd7); check("R9 wrap", addr, 24'h000010);
    dpage = 16'h0300; operand = 24'hABCD45;
    issue(4'd7); check("R9 plain", addr, 24'h000345);
  endtask

  task automatic t_stack;
    sp = 16'h1FF3; emu = 1'b0;
    issue(4'd8); check("R10 native", addr, 24'h001FF3);
    emu = 1'b1;
    issue(4'd8); check("R10 emu", addr, 24'h0001F3);
    emu = 1'b0; sp = 16'h01FE; operand = 24'h777705;
    issue(4'd9); check("R11 rel", addr, 24'h000203);
    sp = 16'hFFFF; operand = 24'h000002;
    issue(4'd9); check("R11 wrap", addr, 24'h000001);
  endtask

  task automatic t_unused;
    issue(4'd12); check("R12 unused", addr, 24'h000000);
    pbr = 8'h44; pc = 16'h4444;
    issue(4'd0); check("R2 refetch", addr, 24'h444444);
    issue(4'd15); check("R12 code15", addr, 24'h000000);
  endtask

  task automatic t_idle;
    pbr = 8'h21; pc = 16'h4321;
    issue(4'd0);
    @(negedge clk);
    pc = 16'h9999; pbr = 8'hEE; mode = 4'd0; req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R13 hold addr", addr, 24'h214321);
    check("R13 valid low", {23'd0, addr_valid}, 24'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_fetch;
    t_pcrel;
    t_int;
    t_data;
    t_direct;
    t_stack;
    t_unused;
    t_idle;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule